// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block is a register-file slave for a serial bus of three wires: an active-high enable, a serial clock and one bidirectional data line. Every transaction opens with a command byte that carries a read/write flag and a starting register address. Data bytes follow. While enable stays high, each further byte moves to the next address, both for writes and for reads. The block holds an array of eight-bit registers and shows their full contents on a wide output bus, so surrounding logic can use them as configuration.

The serial clock polarity is not fixed. At the moment enable rises, the block records the level of the serial clock. That level decides which clock edge samples incoming data and which edge drives outgoing data, and it stays in force until enable rises again.

All three bus inputs come into a faster system clock through two-stage synchronizers, and every bus edge is detected in that clock domain. The data pin is split into an input, an output value and an output enable, and a pad outside the block combines them.

Top module: `tw_slave`

## Requirements
- R1: A transaction starts when enable rises and ends when enable falls. A fall of enable at any point drops the partial byte, returns the block to idle and releases the data pin.
- R2: If the serial clock is low when enable rises, data is sampled on serial-clock falling edges and driven on serial-clock rising edges.
- R3: If the serial clock is high when enable rises, data is sampled on serial-clock rising edges and driven on serial-clock falling edges.
- R4: The captured clock level holds for the whole transaction and is captured again at the next rise of enable.
- R5: In a write, each complete data byte goes to the current address, and the address then steps by one. Address 127 wraps to 0.
- R6: The output enable is high only during the data phase of a read. While the pin is released, the data output is 0.
- R7: The command byte is sent MSB first. Bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the starting register address.
- R8: A written byte changes its register only after all 8 bits have been sampled. A byte cut short by enable falling changes no register.
- R9: In a read, the first driving edge after the command byte presents the MSB of the addressed register. Bits follow MSB first, and the address steps by one (wrapping 127 to 0) after every 8 bits.
- R10: Each output responds to a bus input change at the third system-clock edge after that change.
- R11: After reset, all registers are 0, the output enable is low and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Bus enable, active high, frames a transaction |
| spi_sck | input | 1 | Serial clock |
| spi_din | input | 1 | Data line as seen at the pad input |
| spi_dout | output | 1 | Value driven onto the data line |
| spi_oe | output | 1 | Drive enable for the data line pad |
| reg_image | output | 1024 | All registers, register n at bits 8n+7:8n |

## Verification
Some properties are checked by assertions on every cycle. The pad is driven only in the read phase, and the data output is quiet whenever the pad is released. Enable low releases the pad on the next cycle. The clock level is captured at enable rise and does not change while enable stays high. Every register write happens with enable high and is followed by a one-step address increase.

Other behaviour needs the bench scenarios, which compare every cycle against a behavioural model. These cover which edge samples or drives under each polarity, the exact bit values of burst reads and writes across the address wrap, the loss of a byte cut short by enable, and the three-cycle input-to-output latency.

// File: rtl/tw_pkg.sv
package tw_pkg;

    // transaction phase of the serial slave
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_WR   = 2'd2,
        PH_RD   = 2'd3
    } phase_t;

    // value of the direction flag that selects a read
    localparam logic DIR_READ = 1'b1;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_edge.sv
module tw_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_det
            assign rise_o[g] =  lvl_i[g] & ~prev_q[g];
            assign fall_o[g] = ~lvl_i[g] &  prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [(1<<ADDR_W)*DATA_W-1:0] image_o
);
    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [NREG];
    logic [DATA_W-1:0] mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_img
            assign image_o[g*DATA_W +: DATA_W] = mem_q[g];
        end
    endgenerate
endmodule

// File: rtl/tw_slave.sv
module tw_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_en,
    input  logic                          spi_sck,
    input  logic                          spi_din,
    output logic                          spi_dout,
    output logic                          spi_oe,
    output logic [(1<<ADDR_W)*DATA_W-1:0] reg_image
);
    import tw_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        phase_t            phase;
        logic              pol;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] shreg;
        logic [ADDR_W-1:0] addr;
        logic              oe;
        logic              dout;
    } st_t;

    st_t st_d, st_q;

    // synchronized bus inputs: {en, sck, din}
    logic [2:0] sync_v;
    logic       en_s, sck_s, din_s;
    logic [1:0] rise_v, fall_v;
    logic       en_rise, sck_rise, sck_fall;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_en, spi_sck, spi_din}),
        .sync_o (sync_v)
    );

    assign en_s  = sync_v[2];
    assign sck_s = sync_v[1];
    assign din_s = sync_v[0];

    tw_edge #(.WIDTH(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i ({en_s, sck_s}),
        .rise_o(rise_v),
        .fall_o(fall_v)
    );

    assign en_rise  = rise_v[1];
    assign sck_rise = rise_v[0];
    assign sck_fall = fall_v[0];

    // register array
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    tw_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(st_q.addr),
        .rd_data(rd_data),
        .image_o(reg_image)
    );

    logic              samp_edge, drv_edge, byte_end;
    logic [DATA_W-1:0] full_byte;

    always_comb begin
        // polarity 1 (clock high at enable rise) samples on rising edges
        samp_edge = st_q.pol ? sck_rise : sck_fall;
        drv_edge  = st_q.pol ? sck_fall : sck_rise;
        byte_end  = (st_q.bitcnt == LAST_BIT);
        full_byte = {st_q.shreg[DATA_W-2:0], din_s};

        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.addr;
        wr_data = full_byte;

        if (!en_s) begin
            st_d.phase  = PH_IDLE;
            st_d.bitcnt = '0;
            st_d.oe     = 1'b0;
            st_d.dout   = 1'b0;
        end else if (en_rise) begin
            st_d.phase  = PH_CMD;
            st_d.pol    = sck_s;
            st_d.bitcnt = '0;
            st_d.oe     = 1'b0;
            st_d.dout   = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_CMD: begin
                    if (samp_edge) begin
                        st_d.shreg  = full_byte;
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                        if (byte_end) begin
                            st_d.bitcnt = '0;
                            st_d.addr   = full_byte[ADDR_W-1:0];
                            st_d.phase  = (full_byte[DATA_W-1] == DIR_READ) ? PH_RD : PH_WR;
                        end
                    end
                end
                PH_WR: begin
                    if (samp_edge) begin
                        st_d.shreg  = full_byte;
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                        if (byte_end) begin
                            st_d.bitcnt = '0;
                            wr_en       = 1'b1;
                            st_d.addr   = st_q.addr + 1'b1;
                        end
                    end
                end
                PH_RD: begin
                    if (drv_edge) begin
                        st_d.oe     = 1'b1;
                        st_d.dout   = rd_data[LAST_BIT - st_q.bitcnt];
                        st_d.bitcnt = st_q.bitcnt + 1'b1;
                        if (byte_end) begin
                            st_d.bitcnt = '0;
                            st_d.addr   = st_q.addr + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, pol: 1'b0, bitcnt: '0, shreg: '0,
                      addr: '0, oe: 1'b0, dout: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign spi_dout = st_q.dout;
    assign spi_oe   = st_q.oe;
endmodule

// File: rtl/tw_slave_chk.sv
module tw_slave_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_s,
    input logic              sck_s,
    input logic              en_rise,
    input tw_pkg::phase_t    phase,
    input logic              pol,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              spi_oe,
    input logic              spi_dout
);
    import tw_pkg::*;

    // R6: pad driven only while in the read data phase
    p_oe_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_oe |-> (phase == PH_RD));

    // R6: released pad carries a quiet data output
    p_dout_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_oe |-> !spi_dout);

    // R1: enable low releases the pad on the next cycle
    p_release_on_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (!spi_oe && phase == PH_IDLE));

    // R2 / R3: polarity equals the clock level seen at enable rise
    p_pol_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (pol == $past(sck_s)));

    // R4: polarity unchanged while enable stays high
    p_pol_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && !en_rise) |=> $stable(pol));

    // R8: registers change only inside an open transaction
    p_write_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (en_s && phase == PH_WR));

    // R5: every committed byte advances the address by one
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr == $past(addr) + 1'b1));
endmodule

bind tw_slave tw_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (en_s),
    .sck_s   (sck_s),
    .en_rise (en_rise),
    .phase   (st_q.phase),
    .pol     (st_q.pol),
    .addr    (st_q.addr),
    .wr_en   (wr_en),
    .spi_oe  (spi_oe),
    .spi_dout(spi_dout)
);

// File: tb/tw_slave_tb.sv
`timescale 1ns/1ps
module tw_slave_tb;
    localparam int CLK_NS = 20;
    localparam int HALF   = 4;
    localparam int NREG   = 128;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_en = 1'b0, spi_sck = 1'b0, spi_din = 1'b0;
    logic spi_dout, spi_oe;
    logic [NREG*8-1:0] reg_image;

    always #(CLK_NS/2) clk = ~clk;

    tw_slave u_dut (
        .clk(clk), .rst_n(rst_n),
        .spi_en(spi_en), .spi_sck(spi_sck), .spi_din(spi_din),
        .spi_dout(spi_dout), .spi_oe(spi_oe), .reg_image(reg_image)
    );

    typedef struct packed { logic en; logic sck; logic din; } stim_t;
    typedef struct packed { logic oe; logic dout; logic [NREG*8-1:0] img; } snap_t;

    stim_t stim_q[$];
    snap_t exp_q[$];

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0] m_mem [NREG];
    bit m_pen = 0, m_psck = 0, m_pol = 0, m_oe = 0, m_dout = 0;
    int m_phase = 0;  // 0 idle, 1 command, 2 write, 3 read
    int m_bits  = 0;
    int m_addr  = 0;
    logic [7:0] m_sh = '0;

    function automatic snap_t snap();
        snap_t s;
        s.oe = m_oe;
        s.dout = m_dout;
        for (int i = 0; i < NREG; i++) s.img[i*8 +: 8] = m_mem[i];
        return s;
    endfunction

    task automatic model_step(stim_t s);
        bit rise, fall, samp, drv;
        rise = s.sck && !m_psck;
        fall = !s.sck && m_psck;
        samp = m_pol ? rise : fall;
        drv  = m_pol ? fall : rise;
        if (!s.en) begin
            m_phase = 0; m_bits = 0; m_oe = 0; m_dout = 0;
        end else if (!m_pen) begin
            m_pol = s.sck; m_phase = 1; m_bits = 0; m_oe = 0; m_dout = 0;
        end else if ((m_phase == 1 || m_phase == 2) && samp) begin
            m_sh = {m_sh[6:0], s.din};
            m_bits++;
            if (m_bits == 8) begin
                m_bits = 0;
                if (m_phase == 1) begin
                    m_addr  = int'(m_sh[6:0]);
                    m_phase = m_sh[7] ? 3 : 2;
                end else begin
                    m_mem[m_addr] = m_sh;
                    m_addr = (m_addr + 1) % NREG;
                end
            end
        end else if (m_phase == 3 && drv) begin
            m_oe = 1;
            m_dout = m_mem[m_addr][7 - m_bits];
            m_bits++;
            if (m_bits == 8) begin
                m_bits = 0;
                m_addr = (m_addr + 1) % NREG;
            end
        end
        m_pen = s.en;
        m_psck = s.sck;
    endtask

    task automatic put(bit e, bit s, bit d, int n);
        repeat (n) stim_q.push_back(stim_t'{en: e, sck: s, din: d});
    endtask

    // cut_bits < 0 sends everything; otherwise enable drops after that many bits
    task automatic xfer(bit pol, logic [7:0] bytes[$], int cut_bits);
        int n = 0;
        bit stop = 0;
        put(0, pol, 0, 6);
        put(1, pol, 0, 6);
        foreach (bytes[k]) begin
            for (int b = 7; b >= 0; b--) begin
                if (cut_bits >= 0 && n == cut_bits) stop = 1;
                if (!stop) begin
                    put(1, !pol, bytes[k][b], HALF);
                    put(1,  pol, bytes[k][b], HALF);
                    n++;
                end
            end
        end
        put(1, pol, 0, 6);
        put(0, pol, 0, 6);
    endtask

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] dut_reg(int a);
        return reg_image[a*8 +: 8];
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_mem[i] = '0;
        // R7/R8: write 5A, C3 starting at 0x10, clock idle low (R2)
        xfer(0, '{8'h10, 8'h5A, 8'hC3}, -1);
        // R9: burst read of 0x10..0x11, clock idle high (R3, R4)
        xfer(1, '{8'h90, 8'h00, 8'h00}, -1);
        // R5: burst write across the top address
        xfer(1, '{8'h7F, 8'hA5, 8'h3C}, -1);
        // R9: burst read across the wrap
        xfer(0, '{8'hFF, 8'h00, 8'h00}, -1);
        // R8: second byte cut after 5 bits
        xfer(0, '{8'h20, 8'h77, 8'h99}, 21);
        // R1: read cut in the middle of its first byte
        xfer(1, '{8'hA0, 8'h00}, 12);
        // R1: command itself cut after 3 bits
        xfer(0, '{8'h55}, 3);
        // R6: read of a zero register keeps pad driven with data 0
        xfer(1, '{8'hC5, 8'h00}, -1);

        for (int i = 0; i < LAT; i++) exp_q.push_back(snap());

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(reg_image == '0, "R11", "reg image after reset", 64'(reg_image[63:0]), 64'h0);
        chk(spi_oe == 1'b0 && spi_dout == 1'b0, "R11", "pad state after reset",
            {62'h0, spi_oe, spi_dout}, 64'h0);

        while (stim_q.size() > 0 || exp_q.size() > 0) begin
            snap_t e;
            @(negedge clk);
            e = exp_q.pop_front();
            chk(spi_oe == e.oe, "R1/R2/R3/R4/R6/R10", "output enable", 64'(spi_oe), 64'(e.oe));
            chk(spi_dout == e.dout, "R2/R3/R9/R10", "data output", 64'(spi_dout), 64'(e.dout));
            checks++;
            if (reg_image != e.img) begin
                fails++;
                $display("FAIL R5/R7/R8 register image: actual=%0h expected=%0h",
                         reg_image[1023:960], e.img[1023:960]);
            end
            if (stim_q.size() > 0) begin
                stim_t s;
                s = stim_q.pop_front();
                spi_en = s.en; spi_sck = s.sck; spi_din = s.din;
                model_step(s);
                exp_q.push_back(snap());
            end
        end

        // fixed expected contents from the scenarios
        chk(dut_reg(8'h10) == 8'h5A, "R7", "reg 0x10", 64'(dut_reg(8'h10)), 64'h5A);
        chk(dut_reg(8'h11) == 8'hC3, "R5", "reg 0x11", 64'(dut_reg(8'h11)), 64'hC3);
        chk(dut_reg(8'h7F) == 8'hA5, "R5", "reg 0x7F", 64'(dut_reg(8'h7F)), 64'hA5);
        chk(dut_reg(8'h00) == 8'h3C, "R5", "reg 0x00 after wrap", 64'(dut_reg(8'h00)), 64'h3C);
        chk(dut_reg(8'h20) == 8'h77, "R8", "reg 0x20", 64'(dut_reg(8'h20)), 64'h77);
        chk(dut_reg(8'h21) == 8'h00, "R8", "reg 0x21 cut byte", 64'(dut_reg(8'h21)), 64'h00);
        chk(dut_reg(8'h55) == 8'h00, "R1", "reg 0x55 cut command", 64'(dut_reg(8'h55)), 64'h00);
        chk(spi_oe == 1'b0, "R1", "pad released at end", 64'(spi_oe), 64'h0);

        summary();
        $finish;
    end
endmodule